// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block sits beside a processor's trap logic and decides, every cycle, whether a local interrupt can be taken and which one. It combines the pending and enable vectors, the delegation mask, the current privilege level and the per-level global enable bits. From these it produces a registered result: a valid flag, the cause number of the selected interrupt, and a flag telling the trap logic whether that cause is delegated to supervisor mode.

A virtualization input changes the selection. While it is set, interrupts that belong to the host take precedence, gated by the host's own supervisor enable. When one of them wins, a force-to-host flag is raised. Only when no host interrupt qualifies do the guest interrupt bits compete, under the normal privilege, enable and delegation rules. Outside virtualized operation the guest bits are never eligible.

The selector does not enter the trap and has no register access port. Its result is registered, so the decision made from the inputs present at one rising edge appears on the outputs after that edge.

Top module: `irq_pick_top`

## Requirements
- R1: An interrupt line is a candidate only when both its pending bit and its enable bit are 1. A pending bit alone, or an enable bit alone, never produces a valid result.
- R2: Non-delegated candidates qualify when the privilege level is below machine, or when it is machine (encoding 3) and the machine enable is 1.
- R3: Delegated candidates qualify only when the privilege is user (encoding 0), or when it is supervisor (encoding 1) and the supervisor enable is 1. Privilege encoding 2 is treated as neither user nor supervisor.
- R4: A 1 in the delegation mask at a cause's index sends that cause to supervisor rules. `irqToSup` equals the delegation bit at the reported cause whenever `irqValid` is 1, and is 0 otherwise.
- R5: When several lines qualify, the cause reported is the lowest qualifying index.
- R6: The guest bits sit at indices 2 (software), 6 (timer) and 10 (external). While `virtOn` is 0 they are never selected.
- R7: While `virtOn` is 1, non-guest candidates qualify only when the privilege is user, or supervisor with `hostSIe` at 1. If any qualify, the lowest of them is reported with `forceHost` at 1, and guest lines are not considered.
- R8: While `virtOn` is 1 and no host line qualifies, only the guest bits are candidates. They are judged by the rules of R2 to R4 using `sIe`, and `forceHost` is 0.
- R9: All outputs are registered. They are 0 during reset and change only one rising edge after the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pendVec | input | 12 | Interrupt pending bits |
| enableVec | input | 12 | Interrupt enable bits |
| delegMask | input | 12 | 1 = cause delegated to supervisor |
| privLvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mIe | input | 1 | Machine global interrupt enable |
| sIe | input | 1 | Supervisor global interrupt enable |
| hostSIe | input | 1 | Host supervisor enable, used while virtualized |
| virtOn | input | 1 | Virtualized operation active |
| irqValid | output | 1 | An interrupt may be taken |
| irqCause | output | 4 | Selected cause index |
| irqToSup | output | 1 | Selected cause is delegated to supervisor |
| forceHost | output | 1 | Selected cause must trap to the host |

## Verification
The two functions that can meet in one cycle are host preemption and guest selection. A host line and a guest line can be pending together while virtualized, and the host line must win even when the guest line has the lower index. The bench creates this case on purpose, for example a host line at index 11 against a guest line at index 2. It also sweeps every privilege and enable combination with both virtualization states over pseudo-random pending, enable and delegation vectors. Each result is compared with a bench model that computes the expected cause, delegation flag and force flag from the requirements.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_MACH  = 2'd3
  } privCode_e;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic machOk;
    logic supOk;
    logic hostOk;
    logic virtOn;
  } gateStrobes_t;

endpackage

// File: rtl/irq_pick_ctrl.sv
module irq_pick_ctrl
  import irq_pick_pkg::*;
(
  input  logic [1:0]   privLvl,
  input  logic         mIe,
  input  logic         sIe,
  input  logic         hostSIe,
  input  logic         virtOn,
  output gateStrobes_t gates
);

  logic belowMach;
  logic atMach;
  logic atUser;
  logic atSuper;

  always_comb begin
    belowMach = (privLvl != PRIV_MACH);
    atMach    = (privLvl == PRIV_MACH);
    atUser    = (privLvl == PRIV_USER);
    atSuper   = (privLvl == PRIV_SUPER);

    gates.machOk = belowMach | (atMach & mIe);
    gates.supOk  = atUser | (atSuper & sIe);
    gates.hostOk = atUser | (atSuper & hostSIe);
    gates.virtOn = virtOn;
  end

endmodule

// File: rtl/irq_pick_dp.sv
module irq_pick_dp
  import irq_pick_pkg::*;
#(
  parameter int NUM_IRQ = 12,
  parameter int CW      = $clog2(NUM_IRQ),
  parameter logic [NUM_IRQ-1:0] GUEST_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pendVec,
  input  logic [NUM_IRQ-1:0] enableVec,
  input  logic [NUM_IRQ-1:0] delegMask,
  input  gateStrobes_t       gates,
  output logic               irqValid,
  output logic [CW-1:0]      irqCause,
  output logic               irqToSup,
  output logic               forceHost
);

  function automatic logic [CW-1:0] lowestIdx(input logic [NUM_IRQ-1:0] vec);
    logic [CW-1:0] idx;
    idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (vec[i]) idx = CW'(i);
    end
    return idx;
  endfunction

  logic [NUM_IRQ-1:0] candVec;
  logic [NUM_IRQ-1:0] hostCand;
  logic [NUM_IRQ-1:0] baseCand;
  logic [NUM_IRQ-1:0] takenVec;
  logic [NUM_IRQ-1:0] selVec;
  logic               useHost;
  logic               nextValid;
  logic [CW-1:0]      nextCause;
  logic               nextSup;

  always_comb begin
    candVec  = pendVec & enableVec;
    hostCand = candVec & ~GUEST_MASK & {NUM_IRQ{gates.hostOk}};
    baseCand = gates.virtOn ? (candVec & GUEST_MASK) : (candVec & ~GUEST_MASK);
    takenVec = (baseCand & ~delegMask & {NUM_IRQ{gates.machOk}})
             | (baseCand &  delegMask & {NUM_IRQ{gates.supOk}});
    useHost   = gates.virtOn & (|hostCand);
    selVec    = useHost ? hostCand : takenVec;
    nextValid = |selVec;
    nextCause = lowestIdx(selVec);
    nextSup   = nextValid & delegMask[nextCause];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqValid  <= 1'b0;
      irqCause  <= '0;
      irqToSup  <= 1'b0;
      forceHost <= 1'b0;
    end else begin
      irqValid  <= nextValid;
      irqCause  <= nextValid ? nextCause : '0;
      irqToSup  <= nextSup;
      forceHost <= useHost;
    end
  end

  AST_FORCE_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    forceHost |-> irqValid); // R7

  AST_FORCE_NEEDS_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
    forceHost |-> $past(gates.virtOn)); // R7

  AST_NO_GUEST_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (irqValid && !$past(gates.virtOn)) |-> !((GUEST_MASK >> irqCause) & 1'b1)); // R6

endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top
  import irq_pick_pkg::*;
#(
  parameter int NUM_IRQ    = 12,
  parameter int GUEST_SW   = 2,
  parameter int GUEST_TIM  = 6,
  parameter int GUEST_EXT  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         pendVec,
  input  logic [NUM_IRQ-1:0]         enableVec,
  input  logic [NUM_IRQ-1:0]         delegMask,
  input  logic [1:0]                 privLvl,
  input  logic                       mIe,
  input  logic                       sIe,
  input  logic                       hostSIe,
  input  logic                       virtOn,
  output logic                       irqValid,
  output logic [$clog2(NUM_IRQ)-1:0] irqCause,
  output logic                       irqToSup,
  output logic                       forceHost
);

  localparam int CW = $clog2(NUM_IRQ);
  localparam logic [NUM_IRQ-1:0] GUEST_MASK =
    (NUM_IRQ'(1) << GUEST_SW) | (NUM_IRQ'(1) << GUEST_TIM) | (NUM_IRQ'(1) << GUEST_EXT);

  gateStrobes_t gates;

  irq_pick_ctrl u_ctrl (
    .privLvl (privLvl),
    .mIe     (mIe),
    .sIe     (sIe),
    .hostSIe (hostSIe),
    .virtOn  (virtOn),
    .gates   (gates)
  );

  irq_pick_dp #(
    .NUM_IRQ    (NUM_IRQ),
    .CW         (CW),
    .GUEST_MASK (GUEST_MASK)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pendVec   (pendVec),
    .enableVec (enableVec),
    .delegMask (delegMask),
    .gates     (gates),
    .irqValid  (irqValid),
    .irqCause  (irqCause),
    .irqToSup  (irqToSup),
    .forceHost (forceHost)
  );

  AST_CAUSE_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    irqValid |-> ((($past(pendVec) & $past(enableVec)) >> irqCause) & 1'b1)); // R1

  AST_EMPTY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pendVec & enableVec) == '0) |-> !irqValid); // R1

  AST_MACH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(privLvl) == 2'd3 && !$past(mIe)) |-> !irqValid); // R2

  AST_SUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irqToSup |-> irqValid); // R4

endmodule

// File: tb/irq_pick_top_bench.sv
`timescale 1ns/1ps
module irq_pick_top_bench;

  localparam int N = 12;
  localparam logic [N-1:0] GMASK = 12'b0100_0100_0100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pendVec = '0;
  logic [N-1:0] enableVec = '0;
  logic [N-1:0] delegMask = '0;
  logic [1:0]   privLvl = 2'd0;
  logic         mIe = 1'b0;
  logic         sIe = 1'b0;
  logic         hostSIe = 1'b0;
  logic         virtOn = 1'b0;
  logic         irqValid;
  logic [3:0]   irqCause;
  logic         irqToSup;
  logic         forceHost;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  irq_pick_top u_irq_pick_top (
    .clk(clk), .rst_n(rst_n), .pendVec(pendVec), .enableVec(enableVec),
    .delegMask(delegMask), .privLvl(privLvl), .mIe(mIe), .sIe(sIe),
    .hostSIe(hostSIe), .virtOn(virtOn), .irqValid(irqValid),
    .irqCause(irqCause), .irqToSup(irqToSup), .forceHost(forceHost)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // reference: expected {valid, cause, toSup, force} from the requirements
  function automatic logic [6:0] model(
    input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d,
    input logic [1:0] pr, input logic m, input logic s, input logic hs, input logic v);
    logic mOk, sOk, hOk, found, frc, sup;
    logic [3:0] c;
    mOk = (pr < 2'd3) || m;
    sOk = (pr == 2'd0) || (pr == 2'd1 && s);
    hOk = (pr == 2'd0) || (pr == 2'd1 && hs);
    found = 1'b0; frc = 1'b0; c = 4'd0;
    if (v && hOk) begin
      for (int i = 0; i < N; i++)
        if (!found && p[i] && e[i] && !GMASK[i]) begin
          found = 1'b1; frc = 1'b1; c = 4'(i);
        end
    end
    if (!found) begin
      for (int i = 0; i < N; i++)
        if (!found && p[i] && e[i] && (GMASK[i] == v) && (d[i] ? sOk : mOk)) begin
          found = 1'b1; c = 4'(i);
        end
    end
    sup = found && d[c];
    return {found, c, sup, frc};
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {irqValid, irqCause, irqToSup, forceHost};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got valid=%b cause=%0d sup=%b force=%b expected valid=%b cause=%0d sup=%b force=%b",
        tag, act[6], act[5:2], act[1], act[0], exp[6], exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d,
                       input logic [1:0] pr, input logic m, input logic s,
                       input logic hs, input logic v, input string tag);
    pendVec = p; enableVec = e; delegMask = d; privLvl = pr;
    mIe = m; sIe = s; hostSIe = hs; virtOn = v;
    @(posedge clk);
    @(negedge clk);
    check(tag, model(p, e, d, pr, m, s, hs, v));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", 7'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", 7'b0);

    // R9: new inputs not visible before the edge
    pendVec = 12'h001; enableVec = 12'h001; privLvl = 2'd0;
    #1;
    check("R9 no early change", 7'b0);
    @(posedge clk); @(negedge clk);
    check("R9 one edge later", {1'b1, 4'd0, 1'b0, 1'b0});

    // R1
    apply(12'hFFF, 12'h000, 12'h000, 2'd0, 1, 1, 1, 0, "R1 pending only");
    apply(12'h000, 12'hFFF, 12'h000, 2'd0, 1, 1, 1, 0, "R1 enable only");
    // R5
    apply(12'h228, 12'hFFF, 12'h000, 2'd0, 0, 0, 0, 0, "R5 lowest of 3,5,9");
    apply(12'h800, 12'h800, 12'h000, 2'd0, 0, 0, 0, 0, "R5 top index 11");
    // R2
    apply(12'h008, 12'h008, 12'h000, 2'd3, 0, 1, 1, 0, "R2 machine masked");
    apply(12'h008, 12'h008, 12'h000, 2'd3, 1, 0, 0, 0, "R2 machine enabled");
    // R3 / R4
    apply(12'h020, 12'h020, 12'h020, 2'd1, 1, 0, 0, 0, "R3 supervisor masked");
    apply(12'h020, 12'h020, 12'h020, 2'd1, 0, 1, 0, 0, "R3 R4 delegated taken");
    apply(12'h020, 12'h020, 12'h020, 2'd2, 1, 1, 1, 0, "R3 encoding 2 blocks delegated");
    // R6
    apply(GMASK, GMASK, 12'h000, 2'd0, 1, 1, 1, 0, "R6 guest ignored");
    // R7: host beats lower guest
    apply(12'h804, 12'hFFF, 12'h000, 2'd0, 1, 1, 1, 1, "R7 host over guest");
    apply(12'h804, 12'hFFF, 12'h000, 2'd1, 1, 1, 0, 1, "R7 host gate off");
    // R8
    apply(12'h440, 12'hFFF, 12'h440, 2'd0, 0, 0, 0, 1, "R8 guest only");
    apply(12'h440, 12'hFFF, 12'h440, 2'd1, 1, 0, 0, 1, "R8 guest delegated masked");

    // sweep of privilege, enables and virtualization
    for (int k = 0; k < 40; k++) begin
      logic [N-1:0] p, e, d;
      seed = nextRand(seed); p = seed[11:0]; e = seed[23:12];
      seed = nextRand(seed); d = seed[11:0];
      for (int c = 0; c < 64; c++) begin
        apply(p, e, d, c[1:0], c[2], c[3], c[4], c[5],
              c[5] ? "R7 R8 sweep" : "R2 R3 R4 sweep");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule